// File: doc/BRIEF.md
# Mode-Banked System Control Register File

This block holds a processor's miscellaneous control registers behind one read port and one write port, each addressed by a 6-bit register number. The read port returns data one clock after a read is requested. A write takes effect on the clock edge where it is presented. The saved-status register number has no single backing store. It is steered to one of seven copies according to the mode field of the current status register.

Several registers apply write rules. Masked registers keep their protected bits. Identification registers discard writes. A few numbers always read back a constant. The instruction-set state bits of the status register are not taken from storage on a read. They come from the program-counter input. A write of the status register pushes those bits back into a next-PC value. A mis-programmed coprocessor access register raises a one-cycle error, and so does any access to the unimplemented upper half of the number space.

Register numbers: 0 current status (mode in bits 4:0, T state bit 5, J state bit 24), 1 saved status, 2 FP exception, 3 FP status/control, 4 system control, 5 coprocessor access, 6 TLB type, 7 media feature 0, 8 media feature 1, 9 multiprocessor ID, 10 FP system ID, 11 processor feature 0, 12 cache level ID, 13 cache size ID, 14–31 plain read/write, 32–63 unimplemented.

Top module: `sysreg_file`

## Requirements
- R1: After reset, the status register reads 0x0000_01D3 (supervisor mode) when the PC state bits are zero. The error and next-PC-valid outputs are low, and plain registers read zero.
- R2: `rdData` shows the addressed register in the cycle after `rdEn`. A write is visible to a read issued in the following cycle. Registers 14–31 store full 32-bit values.
- R3: Register 1 maps to a per-mode bank selected by status bits 4:0: 0x11 FIQ, 0x12 IRQ, 0x13 supervisor, 0x16 monitor, 0x17 abort, 0x1B undefined. Reads and writes use the same selection, so each mode's value is independent of the others.
- R4: Mode 0x10 (user) and every other mode value share one unbanked saved-status copy.
- R5: A status read replaces bit 24 with `pcIn[41]` and bit 5 with `pcIn[40]`.
- R6: A status write drives `npcOut`, one cycle later with `npcValid` high for one cycle. The value is `npcIn` with bits 41:40 cleared, then bit 41 set if written bit 24 is 1 and bit 40 set if written bit 5 is 1.
- R7: A write to register 2 changes only bits 30:29.
- R8: A write to register 3 changes only the bits of mask 0xFFF7_009F. All other bits keep their value.
- R9: A write to register 4 keeps bit 27 (reset value 0x08C5_0078). Every other bit takes the written value.
- R10: Writes to registers 6–10 are discarded. Their reset values are 0x0000_0800, 0x1011_0222, 0x0100_0011, 0x8000_0000 and 0x4100_20B0.
- R11: Register 11 always reads 0x0000_1031. Registers 12 and 13 always read zero, whatever was written.
- R12: A write to register 5 stores only bits 23:20 and clears the rest. `errOut` pulses the next cycle if bits 21:20 or bits 23:22 are not both 3.
- R13: A read or write of registers 32–63 pulses `errOut` the next cycle. Such a read returns zero, and such a write changes no storage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| rdEn | input | 1 | Read request |
| rdIdx | input | 6 | Read register number |
| rdData | output | 32 | Read result, valid the cycle after rdEn |
| wrEn | input | 1 | Write request |
| wrIdx | input | 6 | Write register number |
| wrData | input | 32 | Write value |
| pcIn | input | 48 | Current PC; bits 41:40 give J and T state |
| npcIn | input | 48 | Next PC before state-bit update |
| npcOut | output | 48 | Next PC with state bits from a status write |
| npcValid | output | 1 | npcOut valid, one cycle after a status write |
| errOut | output | 1 | Error pulse, one cycle after a faulting access |

## Verification
Every result of this block is registered and appears exactly one cycle after the request: read data, the error pulse and the next-PC update. Write effects appear as data on a read issued one cycle later. The bench drives inputs on the falling edge and holds them over one rising edge. It then samples the outputs at the next falling edge, which is the single cycle in which these results are due. Mode-dependent banking is checked by changing the mode with a status write, then accessing the saved-status number in the next cycle. This confirms that a mode change takes effect for the very next access.

// File: rtl/sysreg_pkg.sv
package sysreg_pkg;
  localparam int DATA_W = 32;
  localparam int IDX_W  = 6;
  localparam int NUM_REGS  = 2 ** (IDX_W - 1);
  localparam int NUM_BANKS = 7;
  localparam int BANK_W    = $clog2(NUM_BANKS);

  localparam logic [IDX_W-1:0] IDX_STAT   = 6'd0;
  localparam logic [IDX_W-1:0] IDX_SAVED  = 6'd1;
  localparam logic [IDX_W-1:0] IDX_FPEXC  = 6'd2;
  localparam logic [IDX_W-1:0] IDX_FPSCR  = 6'd3;
  localparam logic [IDX_W-1:0] IDX_SCTL   = 6'd4;
  localparam logic [IDX_W-1:0] IDX_CPACC  = 6'd5;
  localparam logic [IDX_W-1:0] IDX_TLBTY  = 6'd6;
  localparam logic [IDX_W-1:0] IDX_MEDIA0 = 6'd7;
  localparam logic [IDX_W-1:0] IDX_MEDIA1 = 6'd8;
  localparam logic [IDX_W-1:0] IDX_MPID   = 6'd9;
  localparam logic [IDX_W-1:0] IDX_FPSYS  = 6'd10;
  localparam logic [IDX_W-1:0] IDX_PFEAT0 = 6'd11;
  localparam logic [IDX_W-1:0] IDX_CLVL   = 6'd12;
  localparam logic [IDX_W-1:0] IDX_CSIZE  = 6'd13;

  localparam logic [DATA_W-1:0] FPEXC_MASK = 32'h6000_0000;
  localparam logic [DATA_W-1:0] FPSCR_MASK = 32'hFFF7_009F;
  localparam int                NMFI_POS   = 27;
  localparam logic [DATA_W-1:0] CPACC_KEEP = 32'h00F0_0000;
  localparam logic [DATA_W-1:0] PFEAT0_VAL = 32'h0000_1031;
  localparam int                STAT_J_POS = 24;
  localparam int                STAT_T_POS = 5;

  typedef enum logic [2:0] {RD_STORE, RD_STAT, RD_BANK, RD_CONST, RD_ZERO} rdKind_e;

  typedef struct packed {
    logic              rdValid;
    rdKind_e           rdKind;
    logic [DATA_W-1:0] rdConst;
    logic              wrStore;
    logic              wrBank;
    logic              wrStat;
    logic [BANK_W-1:0] bankSel;
    logic [DATA_W-1:0] wrKeep;
    logic [DATA_W-1:0] wrMask;
  } strobe_t;

  function automatic logic [BANK_W-1:0] bankOfMode(input logic [4:0] mode);
    case (mode)
      5'h11:   return 3'd1;
      5'h12:   return 3'd2;
      5'h13:   return 3'd3;
      5'h16:   return 3'd4;
      5'h17:   return 3'd5;
      5'h1B:   return 3'd6;
      default: return 3'd0;
    endcase
  endfunction

  function automatic logic [DATA_W-1:0] regResetValue(input int idx);
    case (idx)
      0:       return 32'h0000_01D3;
      4:       return 32'h08C5_0078;
      6:       return 32'h0000_0800;
      7:       return 32'h1011_0222;
      8:       return 32'h0100_0011;
      9:       return 32'h8000_0000;
      10:      return 32'h4100_20B0;
      default: return '0;
    endcase
  endfunction
endpackage

// File: rtl/sysreg_ctrl.sv
module sysreg_ctrl
  import sysreg_pkg::*;
#(
  parameter int UNIMP_START = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rdEn,
  input  logic [IDX_W-1:0]  rdIdx,
  input  logic              wrEn,
  input  logic [IDX_W-1:0]  wrIdx,
  input  logic [DATA_W-1:0] wrData,
  input  logic [4:0]        statMode,
  output strobe_t           strb,
  output logic              errOut
);
  localparam logic [IDX_W-1:0] UNIMP_IDX = UNIMP_START[IDX_W-1:0];

  logic rdUnimp, wrUnimp, cpaccBad, errNow;

  assign rdUnimp = rdEn && (rdIdx >= UNIMP_IDX);
  assign wrUnimp = wrEn && (wrIdx >= UNIMP_IDX);

  always_comb begin
    strb         = '0;
    strb.rdKind  = RD_STORE;
    strb.wrKeep  = '1;
    strb.wrMask  = '1;
    strb.bankSel = bankOfMode(statMode);
    strb.rdValid = rdEn;
    cpaccBad     = 1'b0;

    if (rdUnimp) begin
      strb.rdKind = RD_ZERO;
    end else begin
      case (rdIdx)
        IDX_STAT:   strb.rdKind = RD_STAT;
        IDX_SAVED:  strb.rdKind = RD_BANK;
        IDX_PFEAT0: begin
          strb.rdKind  = RD_CONST;
          strb.rdConst = PFEAT0_VAL;
        end
        IDX_CLVL, IDX_CSIZE: strb.rdKind = RD_ZERO;
        default:    strb.rdKind = RD_STORE;
      endcase
    end

    if (wrEn && !wrUnimp) begin
      case (wrIdx)
        IDX_STAT: begin
          strb.wrStore = 1'b1;
          strb.wrStat  = 1'b1;
        end
        IDX_SAVED: strb.wrBank = 1'b1;
        IDX_FPEXC: begin
          strb.wrStore = 1'b1;
          strb.wrMask  = FPEXC_MASK;
        end
        IDX_FPSCR: begin
          strb.wrStore = 1'b1;
          strb.wrMask  = FPSCR_MASK;
        end
        IDX_SCTL: begin
          strb.wrStore = 1'b1;
          strb.wrMask  = ~(DATA_W'(1) << NMFI_POS);
        end
        IDX_CPACC: begin
          strb.wrStore = 1'b1;
          strb.wrKeep  = CPACC_KEEP;
          cpaccBad     = (wrData[21:20] != 2'b11) || (wrData[23:22] != 2'b11);
        end
        IDX_TLBTY, IDX_MEDIA0, IDX_MEDIA1, IDX_MPID, IDX_FPSYS,
        IDX_PFEAT0, IDX_CLVL, IDX_CSIZE: strb.wrStore = 1'b0;
        default: strb.wrStore = 1'b1;
      endcase
    end
  end

  assign errNow = rdUnimp || wrUnimp || cpaccBad;

  always_ff @(posedge clk) begin
    if (!rstN) errOut <= 1'b0;
    else       errOut <= errNow;
  end

  // R13
  err_source_chk: assert property (@(posedge clk) disable iff (!rstN)
    errOut |-> $past(rdEn || wrEn));

  // R13
  unimp_nowrite_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrIdx >= UNIMP_IDX) |-> !(strb.wrStore || strb.wrBank));
endmodule

// File: rtl/sysreg_dp.sv
module sysreg_dp
  import sysreg_pkg::*;
#(
  parameter int PC_W     = 48,
  parameter int PC_T_POS = 40,
  parameter int PC_J_POS = 41
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic [IDX_W-1:0]  rdIdx,
  input  logic [IDX_W-1:0]  wrIdx,
  input  logic [DATA_W-1:0] wrData,
  input  logic [PC_W-1:0]   pcIn,
  input  logic [PC_W-1:0]   npcIn,
  output logic [DATA_W-1:0] rdData,
  output logic [PC_W-1:0]   npcOut,
  output logic              npcValid,
  output logic [4:0]        statMode
);
  localparam logic [PC_W-1:0] PC_STATE_MASK =
    (PC_W'(1) << PC_T_POS) | (PC_W'(1) << PC_J_POS);

  logic [DATA_W-1:0] regs  [NUM_REGS];
  logic [DATA_W-1:0] banks [NUM_BANKS];
  logic [DATA_W-1:0] mergedVal, statView;
  logic [IDX_W-2:0]  wrLo, rdLo;
  logic              unusedBits;

  assign wrLo = wrIdx[IDX_W-2:0];
  assign rdLo = rdIdx[IDX_W-2:0];
  assign unusedBits = ^{pcIn, rdIdx[IDX_W-1], wrIdx[IDX_W-1]};

  assign mergedVal = ((wrData & strb.wrKeep) & strb.wrMask) | (regs[wrLo] & ~strb.wrMask);

  for (genvar i = 0; i < NUM_REGS; i++) begin : gReg
    always_ff @(posedge clk) begin
      if (!rstN) regs[i] <= regResetValue(i);
      else if (strb.wrStore && wrLo == i) regs[i] <= mergedVal;
    end
  end

  for (genvar b = 0; b < NUM_BANKS; b++) begin : gBank
    always_ff @(posedge clk) begin
      if (!rstN) banks[b] <= '0;
      else if (strb.wrBank && strb.bankSel == b) banks[b] <= wrData;
    end
  end

  assign statMode = regs[0][4:0];

  always_comb begin
    statView             = regs[0];
    statView[STAT_J_POS] = pcIn[PC_J_POS];
    statView[STAT_T_POS] = pcIn[PC_T_POS];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdData <= '0;
    end else if (strb.rdValid) begin
      case (strb.rdKind)
        RD_STAT:  rdData <= statView;
        RD_BANK:  rdData <= banks[strb.bankSel];
        RD_CONST: rdData <= strb.rdConst;
        RD_ZERO:  rdData <= '0;
        default:  rdData <= regs[rdLo];
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      npcOut   <= '0;
      npcValid <= 1'b0;
    end else begin
      npcValid <= strb.wrStat;
      if (strb.wrStat)
        npcOut <= (npcIn & ~PC_STATE_MASK)
                | (PC_W'(wrData[STAT_J_POS]) << PC_J_POS)
                | (PC_W'(wrData[STAT_T_POS]) << PC_T_POS);
    end
  end

  // R6
  npc_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    npcValid |-> $past(strb.wrStat));

  // R7
  fpexc_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regs[2] & ~FPEXC_MASK) == ($past(regs[2]) & ~FPEXC_MASK));

  // R9
  nmfi_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    $stable(regs[4][NMFI_POS]));

  // R12
  cpacc_clean_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regs[5] & ~CPACC_KEEP) == '0);

  // R10
  id_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    $stable(regs[9]) && $stable(regs[6]));
endmodule

// File: rtl/sysreg_file.sv
module sysreg_file
  import sysreg_pkg::*;
#(
  parameter int PC_W        = 48,
  parameter int PC_T_POS    = 40,
  parameter int PC_J_POS    = 41,
  parameter int UNIMP_START = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rdEn,
  input  logic [IDX_W-1:0]  rdIdx,
  output logic [DATA_W-1:0] rdData,
  input  logic              wrEn,
  input  logic [IDX_W-1:0]  wrIdx,
  input  logic [DATA_W-1:0] wrData,
  input  logic [PC_W-1:0]   pcIn,
  input  logic [PC_W-1:0]   npcIn,
  output logic [PC_W-1:0]   npcOut,
  output logic              npcValid,
  output logic              errOut
);
  strobe_t    strb;
  logic [4:0] statMode;

  sysreg_ctrl #(.UNIMP_START(UNIMP_START)) uCtrl (
    .clk(clk), .rstN(rstN), .rdEn(rdEn), .rdIdx(rdIdx), .wrEn(wrEn),
    .wrIdx(wrIdx), .wrData(wrData), .statMode(statMode), .strb(strb),
    .errOut(errOut)
  );

  sysreg_dp #(.PC_W(PC_W), .PC_T_POS(PC_T_POS), .PC_J_POS(PC_J_POS)) uDp (
    .clk(clk), .rstN(rstN), .strb(strb), .rdIdx(rdIdx), .wrIdx(wrIdx),
    .wrData(wrData), .pcIn(pcIn), .npcIn(npcIn), .rdData(rdData),
    .npcOut(npcOut), .npcValid(npcValid), .statMode(statMode)
  );
endmodule

// File: tb/sysreg_file_test.sv
`timescale 1ns/1ps
module sysreg_file_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        rdEn = 1'b0, wrEn = 1'b0;
  logic [5:0]  rdIdx = '0, wrIdx = '0;
  logic [31:0] wrData = '0, rdData;
  logic [47:0] pcIn = '0, npcIn = '0, npcOut;
  logic        npcValid, errOut;
  int          checks = 0, errors = 0;
  logic        lastErr, lastNpcValid;
  logic [47:0] lastNpc;

  always #4 clk = ~clk;

  sysreg_file uut (
    .clk(clk), .rstN(rstN), .rdEn(rdEn), .rdIdx(rdIdx), .rdData(rdData),
    .wrEn(wrEn), .wrIdx(wrIdx), .wrData(wrData), .pcIn(pcIn), .npcIn(npcIn),
    .npcOut(npcOut), .npcValid(npcValid), .errOut(errOut)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] idx, input logic [31:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrIdx = idx; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
    lastErr = errOut; lastNpcValid = npcValid; lastNpc = npcOut;
  endtask

  task automatic rd(input logic [5:0] idx, output logic [31:0] v);
    @(negedge clk);
    rdEn = 1'b1; rdIdx = idx;
    @(negedge clk);
    rdEn = 1'b0;
    v = rdData; lastErr = errOut;
  endtask

  task automatic testReset();
    logic [31:0] v;
    chk("R1 err", 64'(errOut), 0);
    chk("R1 npcValid", 64'(npcValid), 0);
    rd(6'd0, v);  chk("R1 status", 64'(v), 64'h1D3);
    rd(6'd20, v); chk("R1 plain", 64'(v), 0);
  endtask

  task automatic testPlain();
    logic [31:0] v;
    wr(6'd20, 32'hDEAD_BEEF);
    rd(6'd20, v); chk("R2 plain rw", 64'(v), 64'hDEAD_BEEF);
    wr(6'd31, 32'h0123_4567);
    rd(6'd31, v); chk("R2 top plain", 64'(v), 64'h0123_4567);
  endtask

  task automatic testStatRead();
    logic [31:0] v;
    pcIn = 48'h0200_0000_0000;
    rd(6'd0, v); chk("R5 J merge", 64'(v), 64'h0100_01D3);
    pcIn = 48'h0100_0000_0000;
    rd(6'd0, v); chk("R5 T merge", 64'(v), 64'h0000_01F3);
    pcIn = '0;
  endtask

  task automatic testNpc();
    npcIn = 48'h0301_2345_6789;
    wr(6'd0, 32'h0000_0033);
    chk("R6 npcValid", 64'(lastNpcValid), 1);
    chk("R6 npc T only", 64'(lastNpc), 64'h0101_2345_6789);
    @(negedge clk);
    chk("R6 pulse ends", 64'(npcValid), 0);
    npcIn = 48'h0000_0000_0010;
    wr(6'd0, 32'h0100_0013);
    chk("R6 npc J only", 64'(lastNpc), 64'h0200_0000_0010);
    npcIn = '0;
  endtask

  task automatic testBanks();
    logic [31:0] v;
    logic [4:0] modes [6] = '{5'h11, 5'h12, 5'h13, 5'h16, 5'h17, 5'h1B};
    for (int k = 0; k < 6; k++) begin
      wr(6'd0, 32'(modes[k]));
      wr(6'd1, 32'h5000_0000 + 32'(k));
    end
    wr(6'd0, 32'h10);
    wr(6'd1, 32'hAAAA_0000);
    for (int k = 0; k < 6; k++) begin
      wr(6'd0, 32'(modes[k]));
      rd(6'd1, v); chk("R3 bank", 64'(v), 64'h5000_0000 + 64'(k));
    end
    wr(6'd0, 32'h1F);
    rd(6'd1, v); chk("R4 unbanked shared", 64'(v), 64'hAAAA_0000);
    wr(6'd1, 32'hBBBB_0000);
    wr(6'd0, 32'h10);
    rd(6'd1, v); chk("R4 user copy", 64'(v), 64'hBBBB_0000);
  endtask

  task automatic testMasks();
    logic [31:0] v;
    wr(6'd2, 32'hFFFF_FFFF);
    rd(6'd2, v); chk("R7 fpexc", 64'(v), 64'h6000_0000);
    wr(6'd3, 32'hFFFF_FFFF);
    rd(6'd3, v); chk("R8 fpscr", 64'(v), 64'hFFF7_009F);
    wr(6'd3, 32'h0);
    rd(6'd3, v); chk("R8 fpscr clr", 64'(v), 0);
    rd(6'd4, v); chk("R9 sctl reset", 64'(v), 64'h08C5_0078);
    wr(6'd4, 32'h0);
    rd(6'd4, v); chk("R9 nmfi kept", 64'(v), 64'h0800_0000);
  endtask

  task automatic testIdFixed();
    logic [31:0] v;
    logic [31:0] exp [5] = '{32'h0000_0800, 32'h1011_0222, 32'h0100_0011,
                             32'h8000_0000, 32'h4100_20B0};
    for (int k = 0; k < 5; k++) begin
      wr(6'(6 + k), 32'h5A5A_5A5A);
      rd(6'(6 + k), v); chk("R10 id ignore", 64'(v), 64'(exp[k]));
    end
    wr(6'd11, 32'hFFFF_FFFF);
    rd(6'd11, v); chk("R11 pfeat0", 64'(v), 64'h1031);
    wr(6'd12, 32'hFFFF_FFFF);
    rd(6'd12, v); chk("R11 clvl", 64'(v), 0);
    rd(6'd13, v); chk("R11 csize", 64'(v), 0);
  endtask

  task automatic testCpacc();
    logic [31:0] v;
    wr(6'd5, 32'hFFFF_FFFF);
    chk("R12 ok no err", 64'(lastErr), 0);
    rd(6'd5, v); chk("R12 keep", 64'(v), 64'h00F0_0000);
    wr(6'd5, 32'h0050_0000);
    chk("R12 bad err", 64'(lastErr), 1);
    rd(6'd5, v); chk("R12 stored", 64'(v), 64'h0050_0000);
  endtask

  task automatic testUnimp();
    logic [31:0] v;
    wr(6'd20, 32'h0000_1234);
    rd(6'd40, v);
    chk("R13 rd zero", 64'(v), 0);
    chk("R13 rd err", 64'(lastErr), 1);
    wr(6'd52, 32'hFFFF_FFFF);
    chk("R13 wr err", 64'(lastErr), 1);
    rd(6'd20, v); chk("R13 no alias", 64'(v), 64'h0000_1234);
    chk("R13 err one cycle", 64'(errOut), 0);
  endtask

  initial begin
    #400000;
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testPlain();
    testStatRead();
    testNpc();
    testBanks();
    testMasks();
    testIdFixed();
    testCpacc();
    testUnimp();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule